// File: doc/BRIEF.md
# Strap-Sampled LED Pin Controller

This block owns a small group of bidirectional pads on a network PHY. Each pad does two jobs. While the hardware (power-on) reset is low, every pad is an input. Its pull-up or pull-down level is captured as one bit of the PHY management address when reset is released. From then on the pad drives a status LED.

The active level of each LED pad is the inverse of the level captured at reset. When the LED is dark, the pad drives its captured level, so the external strap bias stays in place. A status event is chosen for each pad from seven sources through a select register. A software reset puts the selects back to their defaults and darkens the LEDs. It never recaptures the straps, and the pads stay outputs throughout. A captured address of zero holds the MII data path isolated.

Top module: `strap_led_ctrl`

## Requirements
- R1: When pin_i is held stable for at least three clock edges before rst_ni rises, phy_addr_o[i] equals pin_i[i] from the second rising clock edge after the release. Bit 0 is the least significant address bit, so pin 0 high and pin 1 low give address 1.
- R2: pin_oe_o is all zeros while rst_ni is low and after the first rising edge following the release. It is all ones from the second rising edge onward.
- R3: After capture, phy_addr_o does not change, whatever pin_i does.
- R4: When an LED is off, pin_o[i] equals phy_addr_o[i]. When it is on, pin_o[i] is the inverse of phy_addr_o[i].
- R5: mii_iso_o is 1 while the straps are not yet captured. After capture, mii_iso_o is 1 when phy_addr_o is zero and 0 otherwise.
- R6: A select code picks the bit of evt_i that lights the LED: 0 link, 1 activity, 2 transmit, 3 receive, 4 collision, 5 speed, 6 duplex. pin_o follows evt_i one rising edge after evt_i changes.
- R7: A rising edge with sel_we_i high loads sel_code_i into the select of pad sel_pin_i. The new select takes effect on the following edge. After hardware reset, pad 0 selects code 0 and pad 1 selects code 1.
- R8: Select code 7 keeps that LED off whatever evt_i is.
- R9: At a rising edge where sw_rst_i is high, all LEDs turn off and the selects return to their defaults. phy_addr_o and pin_oe_o are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hardware/power-on reset, active low, asynchronous assert |
| sw_rst_i | input | 1 | Software reset, active high, synchronous |
| pin_i | input | NUM_PINS | Pad input levels |
| evt_i | input | 7 | Status events, bit index = select code |
| sel_we_i | input | 1 | Select register write strobe |
| sel_pin_i | input | IDX_W | Pad whose select is written |
| sel_code_i | input | 3 | Select code to write |
| pin_o | output | NUM_PINS | Pad drive levels |
| pin_oe_o | output | NUM_PINS | Pad output enables |
| phy_addr_o | output | NUM_PINS | Captured PHY address |
| mii_iso_o | output | 1 | MII data path isolate |

## Verification
The assertions take four things for granted. sw_rst_i is synchronous. evt_i and the select inputs change only between clock edges. The pad inputs are quiet for the synchronizer depth before rst_ni rises, because the captured value is only defined when that holds. The stimulus changes every input on the falling clock edge. It holds pin_i constant for four cycles of reset before each release, and moves pin_i freely only after capture, which is where the address must ignore it.

// File: rtl/strap_led_pkg.sv
package strap_led_pkg;
  localparam int NUM_EVT = 7;

  typedef enum logic [2:0] {
    EV_LINK   = 3'd0,
    EV_ACT    = 3'd1,
    EV_TX     = 3'd2,
    EV_RX     = 3'd3,
    EV_COL    = 3'd4,
    EV_SPEED  = 3'd5,
    EV_DUPLEX = 3'd6,
    EV_NONE   = 3'd7
  } evt_sel_e;
endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic                ready_o,
  output logic [NUM_PINS-1:0] strap_o
);
  logic [NUM_PINS-1:0] pin_sync_q [SYNC_STAGES];
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic [NUM_PINS-1:0] strap_q;

  // pad synchronizer, unreset so it tracks pads during reset
  always_ff @(posedge clk_i) begin
    pin_sync_q[0] <= pin_i;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_pin_sync
    always_ff @(posedge clk_i) begin
      pin_sync_q[s] <= pin_sync_q[s-1];
    end
  end

  // reset release synchronizer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  // tracks the pads until the release edge, then frozen
  always_ff @(posedge clk_i) begin
    if (!rst_sync_q[SYNC_STAGES-1]) strap_q <= pin_sync_q[SYNC_STAGES-1];
  end

  assign ready_o = rst_sync_q[SYNC_STAGES-1];
  assign strap_o = strap_q;
endmodule

// File: rtl/led_driver.sv
module led_driver
  import strap_led_pkg::*;
#(
  parameter int NUM_PINS = 2,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sw_rst_i,
  input  logic                ready_i,
  input  logic [NUM_EVT-1:0]  evt_i,
  input  logic                sel_we_i,
  input  logic [IDX_W-1:0]    sel_pin_i,
  input  evt_sel_e            sel_code_i,
  output logic [NUM_PINS-1:0] led_o
);
  logic [7:0] evt_ext;
  assign evt_ext = {{(8-NUM_EVT){1'b0}}, evt_i};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_led
    localparam evt_sel_e DEF_SEL = (i == 0) ? EV_LINK : EV_ACT;
    evt_sel_e sel_q;
    logic     led_q;
    logic     hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   sel_q <= DEF_SEL;
      else if (sw_rst_i)                             sel_q <= DEF_SEL;
      else if (sel_we_i && sel_pin_i == IDX_W'(i))   sel_q <= sel_code_i;
    end

    assign hit = (sel_q != EV_NONE) && evt_ext[sel_q];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) led_q <= 1'b0;
      else         led_q <= ready_i && !sw_rst_i && hit;
    end

    assign led_o[i] = led_q;
  end
endmodule

// File: rtl/strap_led_ctrl.sv
module strap_led_ctrl
  import strap_led_pkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sw_rst_i,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_EVT-1:0]  evt_i,
  input  logic                sel_we_i,
  input  logic [IDX_W-1:0]    sel_pin_i,
  input  logic [2:0]          sel_code_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] phy_addr_o,
  output logic                mii_iso_o
);
  logic                ready;
  logic [NUM_PINS-1:0] strap;
  logic [NUM_PINS-1:0] led;

  strap_capture #(
    .NUM_PINS   (NUM_PINS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .ready_o(ready),
    .strap_o(strap)
  );

  led_driver #(
    .NUM_PINS(NUM_PINS)
  ) u_leds (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_rst_i  (sw_rst_i),
    .ready_i   (ready),
    .evt_i     (evt_i),
    .sel_we_i  (sel_we_i),
    .sel_pin_i (sel_pin_i),
    .sel_code_i(evt_sel_e'(sel_code_i)),
    .led_o     (led)
  );

  // asserted level is the inverse of the strap
  assign pin_o      = strap ^ led;
  assign pin_oe_o   = {NUM_PINS{ready}};
  assign phy_addr_o = strap;
  assign mii_iso_o  = !ready || (strap == '0);
endmodule

// File: rtl/strap_led_ctrl_chk.sv
module strap_led_ctrl_chk #(
  parameter int NUM_PINS = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sw_rst_i,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic [NUM_PINS-1:0] phy_addr_o,
  input logic                mii_iso_o
);
  // R2: pads never driven while hardware reset is held
  a_r2_oe_off_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> pin_oe_o == '0);

  // R2: all enables move together
  a_r2_oe_uniform: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o == '0 || pin_oe_o == '1);

  // R3: captured address frozen while pads are outputs
  a_r3_strap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o[0] && $past(pin_oe_o[0])) |-> $stable(phy_addr_o));

  // R5: isolate tracks a zero address after capture
  a_r5_iso_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o[0] |-> (mii_iso_o == (phy_addr_o == '0)));

  // R5: isolated until capture
  a_r5_iso_before_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o[0] |-> mii_iso_o);

  // R9: software reset darkens every LED, pads stay outputs
  a_r9_sw_rst_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rst_i && pin_oe_o[0]) |=> (pin_o == phy_addr_o && pin_oe_o == '1));
endmodule

bind strap_led_ctrl strap_led_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sw_rst_i  (sw_rst_i),
  .pin_o     (pin_o),
  .pin_oe_o  (pin_oe_o),
  .phy_addr_o(phy_addr_o),
  .mii_iso_o (mii_iso_o)
);

// File: tb/strap_led_ctrl_test.sv
module strap_led_ctrl_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] straps;
    logic [6:0] evt;
    logic [1:0] led_on;
    logic       iso;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{straps: 2'b00, evt: 7'h00, led_on: 2'b00, iso: 1'b1},
    '{straps: 2'b01, evt: 7'h01, led_on: 2'b01, iso: 1'b0},
    '{straps: 2'b10, evt: 7'h02, led_on: 2'b10, iso: 1'b0},
    '{straps: 2'b11, evt: 7'h03, led_on: 2'b11, iso: 1'b0},
    '{straps: 2'b01, evt: 7'h7c, led_on: 2'b00, iso: 1'b0},
    '{straps: 2'b10, evt: 7'h7f, led_on: 2'b11, iso: 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_rst = 1'b0;
  logic [1:0] pins = 2'b00;
  logic [6:0] evt = '0;
  logic       sel_we = 1'b0;
  logic [0:0] sel_pin = '0;
  logic [2:0] sel_code = '0;
  logic [1:0] pin_o, pin_oe;
  logic [1:0] addr;
  logic       iso;
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_led_ctrl uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sw_rst_i  (sw_rst),
    .pin_i     (pins),
    .evt_i     (evt),
    .sel_we_i  (sel_we),
    .sel_pin_i (sel_pin),
    .sel_code_i(sel_code),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe),
    .phy_addr_o(addr),
    .mii_iso_o (iso)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk);
    rst_n = 1'b0; pins = s; evt = '0; sw_rst = 1'b0; sel_we = 1'b0;
    step(); step();
    chk("R2 oe low in reset", 32'(pin_oe), 32'h0);
    chk("R5 iso in reset", 32'(iso), 32'h1);
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R2 oe low after first edge", 32'(pin_oe), 32'h0);
    step();
    chk("R2 oe high after capture", 32'(pin_oe), 32'h3);
    chk("R1 strap capture", 32'(addr), 32'(s));
  endtask

  task automatic wr_sel(input logic p, input logic [2:0] c);
    sel_we = 1'b1; sel_pin = p; sel_code = c;
    step();
    sel_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int k = 0; k < 6; k++) begin
      do_reset(VECS[k].straps);
      chk("R5 iso vs address", 32'(iso), 32'(VECS[k].iso));
      chk("R4 idle level equals strap", 32'(pin_o), 32'(VECS[k].straps));
      evt = VECS[k].evt;
      step();
      chk("R6 R4 led level", 32'(pin_o), 32'(VECS[k].straps ^ VECS[k].led_on));
    end

    // straps 10 captured, evt 7f -> both LEDs on
    pins = 2'b01;
    repeat (4) step();
    chk("R3 addr ignores pads", 32'(addr), 32'h2);
    chk("R3 R4 leds still lit", 32'(pin_o), 32'h1);

    sw_rst = 1'b1;
    step();
    chk("R9 leds dark in sw reset", 32'(pin_o), 32'h2);
    chk("R9 oe kept", 32'(pin_oe), 32'h3);
    chk("R9 addr kept", 32'(addr), 32'h2);
    chk("R5 iso in sw reset", 32'(iso), 32'h0);
    sw_rst = 1'b0;
    step();
    chk("R9 leds resume", 32'(pin_o), 32'h1);

    // R7: pad 0 to collision
    evt = 7'h10;
    wr_sel(1'b0, 3'd4);
    step();
    chk("R7 select collision", 32'(pin_o), 32'h3);

    // R6: pad 1 to speed
    evt = 7'h20;
    wr_sel(1'b1, 3'd5);
    step();
    chk("R6 select speed", 32'(pin_o), 32'h0);

    // R6: duplex on pad 1, transmit on pad 0
    evt = 7'h44;
    wr_sel(1'b1, 3'd6);
    wr_sel(1'b0, 3'd2);
    step();
    chk("R6 duplex and transmit", 32'(pin_o), 32'h1);

    // R8: code 7 never lights
    evt = 7'h7f;
    wr_sel(1'b0, 3'd7);
    step();
    chk("R8 unused code dark", 32'(pin_o[0]), 32'h0);
    chk("R8 other pad lit", 32'(pin_o[1]), 32'h0);

    // R9 / R7: defaults restored (pad0 link, pad1 activity)
    sw_rst = 1'b1;
    step();
    sw_rst = 1'b0;
    evt = 7'h01;
    step();
    chk("R9 R7 default selects", 32'(pin_o), 32'h3);
    evt = 7'h02;
    step();
    chk("R7 default activity on pad 1", 32'(pin_o), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule